// File: doc/BRIEF.md
# BCD Hours-Minutes-Seconds Countdown Timer

This block holds a preset duration as three two-digit BCD fields (hours, minutes, seconds). While its run input is high and no field is being edited, each one-second tick strobe removes one second from the value. Seconds and minutes each span 00 to 59 and hours span 00 to 23. Borrows pass from seconds to minutes and from minutes to hours. When the value reaches 00:00:00 it stays there and raises a zero flag. It does not wrap. A separate warning flag is high over the final ten seconds, so an external tone generator can be driven from it.

A setting controller picks one field through a select code. It can then write a BCD value into that field, or step it up or down by one unit. Stepping wraps inside the field and never touches the other fields. While any field is selected, ticks do not change the count. All state changes happen on the rising clock edge. The two flags are decoded from the stored fields without a register.

Top module: `bcd_countdown`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge clears all three fields to 00. After reset `zero` is 1 and `last_ten` is 0.
- R2: With `edit_sel` = 0, each clock edge that sees `tick`=1 and `run`=1 lowers the value by one second. An edge with `run`=0 leaves the value unchanged.
- R3: Seconds count down in BCD. A units digit of 0 becomes 9 and takes one from the tens digit. A seconds value of 00 becomes 59 and produces a borrow.
- R4: A borrow from seconds lowers minutes by one, with 00 becoming 59 and a borrow to hours. Hours count down in BCD, so a units digit of 0 becomes 9 and takes one from the tens digit (10:00:00 goes to 09:59:59).
- R5: At 00:00:00 further ticks leave the value at 00:00:00. `zero` is 1 exactly when all fields are 00.
- R6: `last_ten` is 1 exactly when the value lies from 00:00:01 to 00:00:10, both ends included.
- R7: `edit_sel` codes are 0 = no field, 1 = hours, 2 = minutes, 3 = seconds. `step_up` adds one to the selected field only. Seconds and minutes wrap 59 to 00, and hours wrap 23 to 00.
- R8: `step_dn` subtracts one from the selected field only. Seconds and minutes wrap 00 to 59, and hours wrap 00 to 23.
- R9: `load_en` writes the BCD byte `load_val` (tens digit in bits 7:4, units digit in bits 3:0) into the selected field, but only when both digits are at most 9 and the value is within the field's range. Otherwise the load is ignored. Precedence is load over step_up over step_dn.
- R10: While `edit_sel` is nonzero, ticks with `run`=1 do not change the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle strobe, once per second |
| run | input | 1 | Count enable |
| edit_sel | input | 2 | Field chosen for editing (0 none, 1 hours, 2 minutes, 3 seconds) |
| load_en | input | 1 | Write load_val into the chosen field |
| load_val | input | 8 | BCD value to write |
| step_up | input | 1 | Add one to the chosen field |
| step_dn | input | 1 | Subtract one from the chosen field |
| hours | output | 8 | BCD hours |
| minutes | output | 8 | BCD minutes |
| seconds | output | 8 | BCD seconds |
| zero | output | 1 | Value is 00:00:00 |
| last_ten | output | 1 | Value is within the final ten seconds |

## Verification
The countdown is started from several presets that each exercise a different borrow depth. A seconds value with a nonzero units digit checks a plain units decrement. A units digit of 0 checks the step into the tens digit. Whole minutes check a seconds-to-minutes borrow, and whole hours such as 10:00:00 and 01:00:00 check the full chain, including the hours tens borrow. A run from 00:00:12 down past zero separates the correct ten-second window from windows that are one second off, and it shows that the count sticks at zero. Field edits at each wrap point, together with out-of-range and non-decimal loads, separate field-local wrapping from carries that leak into other fields.

// File: rtl/bcdt_pkg.sv
package bcdt_pkg;
  localparam int FW = 8;
  typedef logic [FW-1:0] bcd2_t;

  function automatic logic bcd_ok(input bcd2_t v, input bcd2_t top);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= top);
  endfunction

  function automatic bcd2_t bcd_dec(input bcd2_t v, input bcd2_t top);
    if (v == '0)             return top;
    else if (v[3:0] == 4'd0) return {v[7:4] - 4'd1, 4'd9};
    else                     return {v[7:4], v[3:0] - 4'd1};
  endfunction

  function automatic bcd2_t bcd_inc(input bcd2_t v, input bcd2_t top);
    if (v == top)            return '0;
    else if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                     return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/bcdt_field.sv
module bcdt_field
  import bcdt_pkg::*;
#(
  parameter bcd2_t TOP = 8'h59
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  logic  ld,
  input  bcd2_t ld_val,
  input  logic  up,
  input  logic  dn,
  input  logic  cnt_en,
  output bcd2_t val,
  output logic  borrow
);
  logic  ld_good;
  bcd2_t nxt;

  assign ld_good = ld && bcd_ok(ld_val, TOP);
  assign borrow  = cnt_en && (val == '0);

  always_comb begin
    nxt = val;
    if (sel) begin
      if (ld_good)  nxt = ld_val;
      else if (up)  nxt = bcd_inc(val, TOP);
      else if (dn)  nxt = bcd_dec(val, TOP);
    end else if (cnt_en) begin
      nxt = bcd_dec(val, TOP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) val <= '0;
    else        val <= nxt;
  end

  a_r3_field_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_ok(val, TOP));
  a_r2_field_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !sel) |=> (val != $past(val)));
  a_r9_bad_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ld && !bcd_ok(ld_val, TOP) && !up && !dn) |=> $stable(val));
endmodule

// File: rtl/bcdt_ctrl.sv
module bcdt_ctrl
  import bcdt_pkg::*;
#(
  parameter bcd2_t WARN_SECS = 8'h10
) (
  input  bcd2_t hh,
  input  bcd2_t mm,
  input  bcd2_t ss,
  input  logic  tick,
  input  logic  run,
  input  logic  editing,
  output logic  count_go,
  output logic  zero,
  output logic  last_ten
);
  logic upper_clear;

  assign upper_clear = (hh == '0) && (mm == '0);
  assign zero        = upper_clear && (ss == '0);
  assign last_ten    = upper_clear && (ss != '0) && (ss <= WARN_SECS);
  assign count_go    = tick && run && !editing && !zero;
endmodule

// File: rtl/bcd_countdown.sv
module bcd_countdown
  import bcdt_pkg::*;
#(
  parameter bcd2_t SEC_TOP   = 8'h59,
  parameter bcd2_t MIN_TOP   = 8'h59,
  parameter bcd2_t HR_TOP    = 8'h23,
  parameter bcd2_t WARN_SECS = 8'h10,
  parameter int    SELW      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            run,
  input  logic [SELW-1:0] edit_sel,
  input  logic            load_en,
  input  logic [FW-1:0]   load_val,
  input  logic            step_up,
  input  logic            step_dn,
  output logic [FW-1:0]   hours,
  output logic [FW-1:0]   minutes,
  output logic [FW-1:0]   seconds,
  output logic            zero,
  output logic            last_ten
);
  localparam int NF = 3;

  logic         editing;
  logic         count_go;
  logic [NF:0]  chain;
  bcd2_t        fv [NF];

  assign editing  = (edit_sel != '0);
  assign chain[0] = count_go;

  // field 0 = seconds (code 3), 1 = minutes (code 2), 2 = hours (code 1)
  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam bcd2_t TOPV = (g == 0) ? SEC_TOP : (g == 1) ? MIN_TOP : HR_TOP;
    logic sel_g;
    assign sel_g = (edit_sel == SELW'(NF - g));
    bcdt_field #(.TOP(TOPV)) u_f (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel_g),
      .ld     (load_en),
      .ld_val (load_val),
      .up     (step_up),
      .dn     (step_dn),
      .cnt_en (chain[g]),
      .val    (fv[g]),
      .borrow (chain[g+1])
    );
  end

  assign seconds = fv[0];
  assign minutes = fv[1];
  assign hours   = fv[2];

  bcdt_ctrl #(.WARN_SECS(WARN_SECS)) u_ctrl (
    .hh       (hours),
    .mm       (minutes),
    .ss       (seconds),
    .tick     (tick),
    .run      (run),
    .editing  (editing),
    .count_go (count_go),
    .zero     (zero),
    .last_ten (last_ten)
  );

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_en && !step_up && !step_dn) |=> $stable({hours, minutes, seconds}));
  a_r5_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !editing) |=> zero);
  a_r6_warn_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ten && count_go) |=> (last_ten || zero));
  a_r10_edit_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (editing && !load_en && !step_up && !step_dn) |=> $stable({hours, minutes, seconds}));
  a_r4_no_hours_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !chain[NF]);
endmodule

// File: tb/sim_bcd_countdown.sv
module sim_bcd_countdown;
  logic       clk = 1'b0;
  logic       rst_n, tick, run, load_en, step_up, step_dn;
  logic [1:0] edit_sel;
  logic [7:0] load_val;
  logic [7:0] hours, minutes, seconds;
  logic       zero, last_ten;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bcd_countdown u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .edit_sel(edit_sel),
    .load_en(load_en), .load_val(load_val), .step_up(step_up), .step_dn(step_dn),
    .hours(hours), .minutes(minutes), .seconds(seconds), .zero(zero), .last_ten(last_ten)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic chk_time(input string req, input int total);
    chk({req, " total seconds"}, b2i(hours) * 3600 + b2i(minutes) * 60 + b2i(seconds), total);
    chk({req, " zero"}, int'(zero), int'(total == 0));
    chk({req, " last_ten"}, int'(last_ten), int'(total >= 1 && total <= 10));
  endtask

  task automatic idle();
    tick = 0; run = 0; edit_sel = 0; load_en = 0; load_val = 0; step_up = 0; step_dn = 0;
  endtask

  // one clock with the given inputs; return at the following falling edge
  task automatic cyc();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic load(input logic [1:0] s, input logic [7:0] v);
    edit_sel = s; load_en = 1; load_val = v; cyc();
  endtask

  task automatic preset(input int h, input int m, input int s);
    load(2'd1, 8'((h / 10) * 16 + h % 10));
    load(2'd2, 8'((m / 10) * 16 + m % 10));
    load(2'd3, 8'((s / 10) * 16 + s % 10));
  endtask

  task automatic sec_tick(input logic r);
    tick = 1; run = r; cyc();
  endtask

  task automatic t_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1;
    chk_time("R1 reset", 0);
  endtask

  task automatic t_borrows();
    preset(10, 0, 0); chk_time("R9 preset load", 36000);
    sec_tick(1); chk_time("R4 hours tens borrow", 35999);
    chk("R4 hours digits", int'(hours), 'h09);
    preset(1, 0, 0); sec_tick(1); chk_time("R4 minutes to hours", 3599);
    preset(0, 1, 0); sec_tick(1); chk_time("R4 seconds to minutes", 59);
    preset(2, 30, 20); sec_tick(1); chk_time("R3 seconds units borrow", 2*3600 + 30*60 + 19);
    chk("R3 seconds digits", int'(seconds), 'h19);
    sec_tick(1); chk_time("R2 plain decrement", 2*3600 + 30*60 + 18);
  endtask

  task automatic t_hold();
    preset(0, 5, 7);
    for (int i = 0; i < 3; i++) sec_tick(0);
    chk_time("R2 run low holds", 307);
    edit_sel = 2'd3; tick = 1; run = 1; cyc();
    chk_time("R10 edit blocks count", 307);
  endtask

  task automatic t_steps();
    preset(23, 59, 59);
    edit_sel = 2'd3; step_up = 1; cyc();
    chk_time("R7 seconds wrap up no carry", 23*3600 + 59*60);
    edit_sel = 2'd3; step_dn = 1; cyc();
    chk_time("R8 seconds wrap down no borrow", 23*3600 + 59*60 + 59);
    edit_sel = 2'd1; step_up = 1; cyc();
    chk_time("R7 hours wrap 23 to 00", 59*60 + 59);
    edit_sel = 2'd1; step_dn = 1; cyc();
    chk_time("R8 hours wrap 00 to 23", 23*3600 + 59*60 + 59);
    edit_sel = 2'd2; step_up = 1; cyc();
    chk_time("R7 minutes wrap up", 23*3600 + 59);
    edit_sel = 2'd2; step_dn = 1; cyc();
    chk_time("R8 minutes wrap down", 23*3600 + 59*60 + 59);
    edit_sel = 2'd0; step_up = 1; cyc();
    chk_time("R7 no field selected", 23*3600 + 59*60 + 59);
  endtask

  task automatic t_loads();
    preset(4, 30, 30);
    load(2'd3, 8'h60); chk_time("R9 seconds out of range ignored", 4*3600 + 30*60 + 30);
    load(2'd2, 8'h1A); chk_time("R9 non-decimal digit ignored", 4*3600 + 30*60 + 30);
    load(2'd1, 8'h24); chk_time("R9 hours out of range ignored", 4*3600 + 30*60 + 30);
    edit_sel = 2'd3; load_en = 1; load_val = 8'h05; step_up = 1; cyc();
    chk_time("R9 load beats step", 4*3600 + 30*60 + 5);
    edit_sel = 2'd3; step_up = 1; step_dn = 1; cyc();
    chk_time("R9 step_up beats step_dn", 4*3600 + 30*60 + 6);
  endtask

  task automatic t_tail();
    preset(0, 0, 12);
    for (int k = 11; k >= 0; k--) begin
      sec_tick(1); chk_time("R6 countdown tail", k);
    end
    sec_tick(1); sec_tick(1);
    chk_time("R5 stays at zero", 0);
  endtask

  initial begin
    idle(); rst_n = 0;
    @(negedge clk);
    t_reset();
    t_borrows();
    t_hold();
    t_steps();
    t_loads();
    t_tail();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule